// File: doc/BRIEF.md
# Receive Buffer Pause Watermark Controller

This block watches how many bytes sit in a receive FIFO and decides when the transmit side should send an IEEE 802.3x PAUSE frame. When occupancy reaches a high threshold it raises a pause request that carries a programmable quanta value. The block then stays in a paused state until occupancy drops under a low threshold. At that point it raises a resume request with zero quanta and returns to idle.

Both thresholds are programmed in units of 8 bytes. A high threshold of zero turns transmit flow control off. While paused, a refresh interval makes the block issue the pause request again, so the link partner keeps holding off for as long as the FIFO stays full. Every request stays asserted until the transmit path acknowledges it. The block builds no frames itself: a MAC transmit path consumes the request, sends the frame and pulses the acknowledge.

Top module: `rxq_pause_ctl`

## Requirements
- R1: After reset, `pause_req`, `resume_req` and `paused` are 0 and `req_quanta` is 0.
- R2: Thresholds are in 8-byte units. From idle, with `cfg_hi_wm` = H (H not 0), a pause request is raised on the first clock edge at which `fifo_occ` >= 8*H. An occupancy of 8*H-1 raises nothing.
- R3: When `cfg_hi_wm` is 0, no pause request is ever raised from idle, whatever the occupancy.
- R4: A pause request carries the value of `cfg_quanta` sampled at the edge that raises it, and `paused` becomes 1 on that same edge.
- R5: A request and its `req_quanta` stay unchanged until `tx_ack` is seen high at a clock edge. That edge clears the request, and `req_quanta` returns to 0.
- R6: While paused with no request outstanding, `fifo_occ` < 8*`cfg_lo_wm` raises a resume request with `req_quanta` = 0 and clears `paused` on the same edge. An occupancy of exactly 8*`cfg_lo_wm` raises nothing.
- R7: Setting `cfg_hi_wm` to 0 while paused raises a resume request and returns the block to idle, even if occupancy is still high.
- R8: While paused above the low threshold with `cfg_refresh` = L (L not 0), a new pause request is raised L+1 clock edges after the edge that accepted the previous acknowledge. It carries the current `cfg_quanta`.
- R9: With `cfg_refresh` = 0, no repeated pause request is raised while paused.
- R10: At most one request is outstanding at a time, and pause and resume are never raised together. A condition that arises while a request is outstanding is acted on only after that request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_occ | input | OCC_W (17) | Receive FIFO occupancy in bytes |
| cfg_hi_wm | input | WM_W (14) | High threshold in 8-byte units; 0 disables flow control |
| cfg_lo_wm | input | WM_W (14) | Low threshold in 8-byte units |
| cfg_quanta | input | QUANTA_W (16) | Quanta value placed in pause requests |
| cfg_refresh | input | TMR_W (16) | Refresh interval in clock cycles; 0 disables refresh |
| tx_ack | input | 1 | Transmit path has taken the outstanding request |
| pause_req | output | 1 | Pause frame requested |
| resume_req | output | 1 | Zero-quanta resume frame requested |
| req_quanta | output | QUANTA_W (16) | Quanta of the outstanding request |
| paused | output | 1 | Controller is in the paused state |

## Verification
On every cycle the assertions check four things: pause and resume are mutually exclusive, an unacknowledged request holds its value, a resume always carries zero quanta, and entering or leaving the paused state coincides with the matching request. They also check that flow-control-off idle never raises a pause and that the refresh counter clears on an acknowledge. Only the bench scenarios show the exact 8-byte threshold boundaries, the L+1 refresh spacing measured from the acknowledge, the quanta resampling on refresh, and the deferral of a new pause until an outstanding resume is acknowledged.

// File: rtl/rxq_pause_pkg.sv
package rxq_pause_pkg;

  // Controller state: idle, or holding the link partner off.
  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_PAUSED = 1'b1
  } pstate_e;

endpackage

// File: rtl/rxq_wm_compare.sv
// Converts 8-byte-unit thresholds to bytes and compares them to occupancy.
module rxq_wm_compare #(
  parameter int OCC_W = 17,
  parameter int WM_W  = 14
) (
  input  logic [OCC_W-1:0] occ,
  input  logic [WM_W-1:0]  hi_wm,
  input  logic [WM_W-1:0]  lo_wm,
  output logic             fc_on,
  output logic             at_hi,
  output logic             under_lo
);
  localparam int CMP_W = (OCC_W > WM_W + 3) ? OCC_W : WM_W + 3;

  // Threshold unit is 8 bytes: shift left by three.
  function automatic logic [CMP_W-1:0] units_to_bytes(input logic [WM_W-1:0] u);
    return CMP_W'({u, 3'b000});
  endfunction

  logic [CMP_W-1:0] occ_ext;
  logic [CMP_W-1:0] hi_bytes;
  logic [CMP_W-1:0] lo_bytes;

  always_comb begin
    occ_ext  = CMP_W'(occ);
    hi_bytes = units_to_bytes(hi_wm);
    lo_bytes = units_to_bytes(lo_wm);
    fc_on    = (hi_wm != '0);
    at_hi    = fc_on && (occ_ext >= hi_bytes);
    under_lo = (occ_ext < lo_bytes);
  end

endmodule

// File: rtl/rxq_refresh_timer.sv
// Counts cycles while paused with nothing outstanding; flags refresh due.
module rxq_refresh_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q;
  logic             cnt_step;

  assign cnt_step = run && (cnt_q < limit);
  assign expired  = run && (limit != '0) && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (cnt_step) cnt_q <= cnt_q + 1'b1;
  end

  // R8: an acknowledge restarts the refresh interval from zero.
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R8: the interval does not advance while a request is outstanding or idle.
  p_hold_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/rxq_pause_fsm.sv
// Two-state controller with a single outstanding-request register.
module rxq_pause_fsm
  import rxq_pause_pkg::*;
#(
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fc_on,
  input  logic                at_hi,
  input  logic                under_lo,
  input  logic                expired,
  input  logic                tx_ack,
  input  logic [QUANTA_W-1:0] cfg_quanta,
  output logic                pause_req,
  output logic                resume_req,
  output logic [QUANTA_W-1:0] req_quanta,
  output logic                paused,
  output logic                timer_run,
  output logic                timer_restart
);
  pstate_e             state_q;
  logic                pause_q;
  logic                resume_q;
  logic [QUANTA_W-1:0] quanta_q;

  // Named internal events.
  logic have_req;
  logic ev_ack;
  logic ev_issue_pause;
  logic ev_release;
  logic ev_refresh;

  assign have_req       = pause_q || resume_q;
  assign ev_ack         = have_req && tx_ack;
  assign ev_issue_pause = !have_req && (state_q == ST_IDLE) && at_hi;
  assign ev_release     = !have_req && (state_q == ST_PAUSED) && (!fc_on || under_lo);
  assign ev_refresh     = !have_req && (state_q == ST_PAUSED) && !(!fc_on || under_lo)
                          && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pause_q  <= 1'b0;
      resume_q <= 1'b0;
      quanta_q <= '0;
    end else begin
      if (ev_ack) begin
        pause_q  <= 1'b0;
        resume_q <= 1'b0;
        quanta_q <= '0;
      end
      if (ev_issue_pause || ev_refresh) begin
        pause_q  <= 1'b1;
        quanta_q <= cfg_quanta;
      end
      if (ev_issue_pause) state_q <= ST_PAUSED;
      if (ev_release) begin
        resume_q <= 1'b1;
        quanta_q <= '0;
        state_q  <= ST_IDLE;
      end
    end
  end

  assign pause_req     = pause_q;
  assign resume_req    = resume_q;
  assign req_quanta    = quanta_q;
  assign paused        = (state_q == ST_PAUSED);
  assign timer_run     = (state_q == ST_PAUSED) && !have_req;
  assign timer_restart = ev_ack;

  // R10: never both kinds of request at once.
  p_one_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pause_q, resume_q}));

  // R5: an unacknowledged request keeps its kind and quanta.
  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (have_req && !tx_ack) |=> (pause_q == $past(pause_q)) &&
                              (resume_q == $past(resume_q)) && $stable(quanta_q));

  // R6: a resume request always carries zero quanta.
  p_resume_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |-> (quanta_q == '0));

  // R4: entering the paused state coincides with a pause request.
  p_enter_with_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> pause_q);

  // R6: leaving the paused state coincides with a resume request.
  p_leave_with_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> resume_q);

  // R3: with flow control off, idle never produces a pause.
  p_fc_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !fc_on && !have_req) |=> !pause_q);

endmodule

// File: rtl/rxq_pause_ctl.sv
// Receive buffer pause watermark controller, top level.
module rxq_pause_ctl #(
  parameter int OCC_W    = 17,
  parameter int WM_W     = 14,
  parameter int QUANTA_W = 16,
  parameter int TMR_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OCC_W-1:0]    fifo_occ,
  input  logic [WM_W-1:0]     cfg_hi_wm,
  input  logic [WM_W-1:0]     cfg_lo_wm,
  input  logic [QUANTA_W-1:0] cfg_quanta,
  input  logic [TMR_W-1:0]    cfg_refresh,
  input  logic                tx_ack,
  output logic                pause_req,
  output logic                resume_req,
  output logic [QUANTA_W-1:0] req_quanta,
  output logic                paused
);
  logic fc_on;
  logic at_hi;
  logic under_lo;
  logic expired;
  logic timer_run;
  logic timer_restart;

  rxq_wm_compare #(.OCC_W(OCC_W), .WM_W(WM_W)) u_cmp (
    .occ      (fifo_occ),
    .hi_wm    (cfg_hi_wm),
    .lo_wm    (cfg_lo_wm),
    .fc_on    (fc_on),
    .at_hi    (at_hi),
    .under_lo (under_lo)
  );

  rxq_refresh_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timer_run),
    .restart (timer_restart),
    .limit   (cfg_refresh),
    .expired (expired)
  );

  rxq_pause_fsm #(.QUANTA_W(QUANTA_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .fc_on         (fc_on),
    .at_hi         (at_hi),
    .under_lo      (under_lo),
    .expired       (expired),
    .tx_ack        (tx_ack),
    .cfg_quanta    (cfg_quanta),
    .pause_req     (pause_req),
    .resume_req    (resume_req),
    .req_quanta    (req_quanta),
    .paused        (paused),
    .timer_run     (timer_run),
    .timer_restart (timer_restart)
  );

endmodule

// File: tb/rxq_pause_ctl_bench.sv
module rxq_pause_ctl_bench;
  localparam int OCC_W = 17;
  localparam int WM_W  = 14;
  localparam int QW    = 16;
  localparam int TW    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [OCC_W-1:0] fifo_occ = '0;
  logic [WM_W-1:0]  cfg_hi_wm = '0;
  logic [WM_W-1:0]  cfg_lo_wm = '0;
  logic [QW-1:0]    cfg_quanta = '0;
  logic [TW-1:0]    cfg_refresh = '0;
  logic          tx_ack = 1'b0;
  logic          pause_req, resume_req, paused;
  logic [QW-1:0] req_quanta;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  // Scoreboard: kind 1 = pause, 2 = resume; at = expected cycle or -1.
  int    exp_kind[$];
  int    exp_quanta[$];
  int    exp_at[$];
  string exp_tag[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  rxq_pause_ctl u_rxq_pause_ctl (
    .clk(clk), .rst_n(rst_n), .fifo_occ(fifo_occ), .cfg_hi_wm(cfg_hi_wm),
    .cfg_lo_wm(cfg_lo_wm), .cfg_quanta(cfg_quanta), .cfg_refresh(cfg_refresh),
    .tx_ack(tx_ack), .pause_req(pause_req), .resume_req(resume_req),
    .req_quanta(req_quanta), .paused(paused)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_req(input int kind, input int q, input int at, input string tag);
    exp_kind.push_back(kind);
    exp_quanta.push_back(q);
    exp_at.push_back(at);
    exp_tag.push_back(tag);
  endtask

  // Monitor: each newly raised request is popped and compared.
  logic prev_p = 1'b0, prev_r = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ((pause_req && !prev_p) || (resume_req && !prev_r))) begin
      automatic int kind = pause_req ? 1 : 2;
      if (exp_kind.size() == 0) begin
        chk(0, "R10", "unexpected request kind", kind, 0);
      end else begin
        automatic int ek = exp_kind.pop_front();
        automatic int eq = exp_quanta.pop_front();
        automatic int ea = exp_at.pop_front();
        automatic string et = exp_tag.pop_front();
        chk(kind == ek, et, "request kind", kind, ek);
        chk(int'(req_quanta) == eq, et, "request quanta", int'(req_quanta), eq);
        if (ea >= 0) chk(cyc == ea, et, "request cycle", cyc, ea);
      end
    end
    prev_p <= pause_req;
    prev_r <= resume_req;
  end

  task automatic wait_req(input string tag);
    int n = 0;
    @(negedge clk);
    while (!(pause_req || resume_req) && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (n >= 200) chk(0, tag, "request timeout", 0, 1);
  endtask

  // Acknowledge at the current negedge; returns the cycle it was driven in.
  task automatic ack(output int c);
    c = cyc;
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk(!pause_req && !resume_req && !paused && req_quanta == 0, "R1",
        "reset outputs", {pause_req, resume_req, paused}, 0);
    rst_n = 1'b1;
    cfg_hi_wm = 14'd4; cfg_lo_wm = 14'd2; cfg_quanta = 16'h1234; cfg_refresh = '0;

    // R2: one byte under the high threshold raises nothing.
    fifo_occ = 17'd31;
    repeat (8) @(negedge clk);
    chk(!pause_req, "R2", "no pause at 8*H-1", pause_req, 0);

    // R2/R4: reaching 8*H raises a pause with cfg_quanta.
    expect_req(1, 16'h1234, -1, "R4");
    fifo_occ = 17'd32;
    wait_req("R2");
    chk(paused, "R4", "paused with request", paused, 1);

    // R5: request held without acknowledge.
    repeat (4) begin
      @(negedge clk);
      chk(pause_req && req_quanta == 16'h1234, "R5", "held request", req_quanta, 16'h1234);
    end
    ack(c);
    chk(!pause_req && req_quanta == 0, "R5", "cleared after ack", pause_req, 0);

    // R6 boundary and R9: occupancy at 8*lo, refresh off: nothing new.
    fifo_occ = 17'd16;
    repeat (10) @(negedge clk);
    chk(!resume_req && paused, "R6", "no resume at 8*L", resume_req, 0);
    chk(!pause_req, "R9", "no repeat with refresh off", pause_req, 0);

    // R6: below low threshold -> resume with zero quanta.
    expect_req(2, 0, -1, "R6");
    fifo_occ = 17'd15;
    wait_req("R6");
    chk(resume_req && req_quanta == 0 && !paused, "R6", "resume zero quanta idle",
        req_quanta, 0);

    // R10: occupancy high while resume outstanding: pause deferred.
    fifo_occ = 17'd100;
    repeat (4) begin
      @(negedge clk);
      chk(resume_req && !pause_req, "R10", "pause deferred", pause_req, 0);
    end
    expect_req(1, 16'h1234, -1, "R10");
    ack(c);
    wait_req("R10");

    // R8: refresh spacing L+1 edges after the ack edge, quanta resampled.
    cfg_refresh = 16'd6;
    ack(c);
    expect_req(1, 16'h1234, c + 8, "R8");
    wait_req("R8");
    cfg_quanta = 16'h0042;
    ack(c);
    expect_req(1, 16'h0042, c + 8, "R8");
    wait_req("R8");
    ack(c);
    expect_req(2, 0, -1, "R6");
    fifo_occ = '0;
    wait_req("R6");
    ack(c);
    cfg_refresh = '0;

    // R3: high threshold zero disables pause from idle.
    cfg_hi_wm = '0;
    fifo_occ = '1;
    repeat (20) @(negedge clk);
    chk(!pause_req && !paused, "R3", "flow control off", pause_req, 0);

    // R7: turning flow control off while paused releases.
    cfg_hi_wm = 14'd4;
    fifo_occ = 17'd200;
    expect_req(1, 16'h0042, -1, "R4");
    wait_req("R4");
    ack(c);
    expect_req(2, 0, -1, "R7");
    cfg_hi_wm = '0;
    wait_req("R7");
    ack(c);
    chk(!paused && !resume_req, "R7", "idle after release", paused, 0);

    repeat (5) @(negedge clk);
    chk(exp_kind.size() == 0, "R10", "all expected requests seen", exp_kind.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule